// File: doc/BRIEF.md
# Execution Port Steering Logic

This block sits between the issue stage and the execution units of an out-of-order core. Each cycle it receives up to `NUM_SLOTS` ready instructions, each with a valid bit and a 3-bit operation class. It places each instruction on one of six execution units. Two are integer ALUs. The other four are floating-point units: a multiplier, a divider, a square-root unit and a general FP unit. Each unit takes at most one instruction per cycle. A unit that is still busy with a multi-cycle operation receives nothing.

Placement is asymmetric. Some classes are tied to a single unit. Plain integer operations can use either ALU. The block first settles the classes that are tied to one unit, taking the oldest candidate for each unit. Plain integer operations then fill whichever ALU is still open, trying ALU 1 before ALU 2. An instruction that cannot be placed is flagged as stalled. All results pass through a single register stage.

Unit numbering: 0 = ALU 1, 1 = ALU 2, 2 = FP multiplier, 3 = FP divider, 4 = FP square root, 5 = general FPU. Class codes: 0 = plain integer, 1 = branch/shift, 2 = integer multiply/divide, 3 = FP multiply, 4 = FP divide, 5 = FP square root, 6 and 7 = other FP operations. Slot `i` uses bits `[3*i +: 3]` of `slot_cls_i`. Unit `u` reports its slot index in bits `[IW*u +: IW]` of `grant_idx_o`, where IW = clog2(NUM_SLOTS).

Top module: `exec_port_steer`

## Requirements
- R1: A class 1 (branch/shift) instruction is granted only to unit 0.
- R2: A class 2 (integer multiply/divide) instruction is granted only to unit 1.
- R3: A class 0 instruction can go to unit 0 or unit 1. It takes unit 0 when unit 0 is neither busy nor already taken this cycle, and otherwise takes unit 1 if unit 1 is open.
- R4: Classes 3, 4 and 5 are granted only to units 2, 3 and 4 respectively.
- R5: Classes 6 and 7 are granted only to unit 5.
- R6: When several instructions compete for one unit, the lowest slot index wins and the others are stalled. Among class 0 instructions, earlier slots take an ALU before later ones.
- R7: A unit whose `unit_busy_i` bit is 1 gets no grant in the resulting output cycle. Its candidates are stalled.
- R8: Instructions tied to a single unit are placed before class 0 instructions. Each slot is granted to at most one unit.
- R9: `stall_o[i]` is 1 exactly when slot `i` was valid and was not granted. An invalid slot is neither granted nor stalled.
- R10: Grants and stalls appear one clock after the inputs are sampled. While `rst_ni` is low, all grant and stall outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_vld_i | input | NUM_SLOTS | Valid bit for each issue slot |
| slot_cls_i | input | 3*NUM_SLOTS | Operation class for each slot |
| unit_busy_i | input | 6 | Busy bit for each unit |
| grant_vld_o | output | 6 | Grant valid for each unit (registered) |
| grant_idx_o | output | 6*IW | Granted slot index for each unit (registered) |
| stall_o | output | NUM_SLOTS | Slot was valid but not placed (registered) |

## Verification
The bench drives every combination of slot classes and valid bits with no unit busy. This sweep separates correct legality per class from wrong handling of ALU preference and of age order, because every mix of competing slots appears. A second sweep fills all slots and steps through all 64 busy patterns. It shows whether a busy unit is ever granted and whether its candidates fall back to the other ALU or stall. Directed vectors isolate three cases: ALU 1 preference, a younger branch taking ALU 1 from an older plain integer operation, and two slots contending for the FP divider.

// File: rtl/exec_steer_pkg.sv
package exec_steer_pkg;

  localparam int CLS_W     = 3;
  localparam int NUM_UNITS = 6;
  localparam int UNIT_W    = 3;

  typedef enum logic [CLS_W-1:0] {
    OP_INT_ANY    = 3'd0,
    OP_INT_BRSH   = 3'd1,
    OP_INT_MULDIV = 3'd2,
    OP_FP_MUL     = 3'd3,
    OP_FP_DIV     = 3'd4,
    OP_FP_SQRT    = 3'd5,
    OP_FP_GEN     = 3'd6,
    OP_FP_MISC    = 3'd7
  } op_cls_e;

  localparam logic [UNIT_W-1:0] U_ALU1  = 3'd0;
  localparam logic [UNIT_W-1:0] U_ALU2  = 3'd1;
  localparam logic [UNIT_W-1:0] U_FMUL  = 3'd2;
  localparam logic [UNIT_W-1:0] U_FDIV  = 3'd3;
  localparam logic [UNIT_W-1:0] U_FSQRT = 3'd4;
  localparam logic [UNIT_W-1:0] U_FGEN  = 3'd5;
  localparam logic [UNIT_W-1:0] U_NONE  = 3'd7;

  // Unit a class is tied to; U_NONE for classes that may use either ALU.
  function automatic logic [UNIT_W-1:0] home_unit(input logic [CLS_W-1:0] cls);
    logic [UNIT_W-1:0] u;
    case (cls)
      OP_INT_BRSH:   u = U_ALU1;
      OP_INT_MULDIV: u = U_ALU2;
      OP_FP_MUL:     u = U_FMUL;
      OP_FP_DIV:     u = U_FDIV;
      OP_FP_SQRT:    u = U_FSQRT;
      OP_FP_GEN,
      OP_FP_MISC:    u = U_FGEN;
      default:       u = U_NONE;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/steer_pick_oldest.sv
module steer_pick_oldest #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic          blocked_i,
  output logic          win_vld_o,
  output logic [IW-1:0] win_idx_o,
  output logic [N-1:0]  win_1h_o
);

  // Scan from the youngest slot down, so the lowest requesting index is kept.
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_1h_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && !blocked_i) begin
        win_vld_o   = 1'b1;
        win_idx_o   = IW'(i);
        win_1h_o    = '0;
        win_1h_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/steer_flex_fill.sv
module steer_flex_fill #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]         req_i,
  input  logic [1:0]           free_i,
  output logic [1:0]           take_o,
  output logic [1:0][IW-1:0]   take_idx_o,
  output logic [N-1:0]         placed_o
);

  logic [1:0] open_w;

  // Oldest flexible op first; each op tries ALU1, then ALU2.
  always_comb begin
    open_w     = free_i;
    take_o     = '0;
    take_idx_o = '0;
    placed_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        if (open_w[0]) begin
          open_w[0]     = 1'b0;
          take_o[0]     = 1'b1;
          take_idx_o[0] = IW'(i);
          placed_o[i]   = 1'b1;
        end else if (open_w[1]) begin
          open_w[1]     = 1'b0;
          take_o[1]     = 1'b1;
          take_idx_o[1] = IW'(i);
          placed_o[i]   = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/exec_port_steer.sv
module exec_port_steer
  import exec_steer_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SLOTS-1:0]        slot_vld_i,
  input  logic [NUM_SLOTS*CLS_W-1:0]  slot_cls_i,
  input  logic [NUM_UNITS-1:0]        unit_busy_i,
  output logic [NUM_UNITS-1:0]        grant_vld_o,
  output logic [NUM_UNITS*IW-1:0]     grant_idx_o,
  output logic [NUM_SLOTS-1:0]        stall_o
);

  logic [NUM_SLOTS-1:0][CLS_W-1:0]  cls;
  logic [NUM_UNITS-1:0][NUM_SLOTS-1:0] pin_req;
  logic [NUM_SLOTS-1:0]             flex_req;
  logic [NUM_UNITS-1:0]             pin_vld;
  logic [NUM_UNITS-1:0][IW-1:0]     pin_idx;
  logic [NUM_UNITS-1:0][NUM_SLOTS-1:0] pin_1h;
  logic [NUM_SLOTS-1:0]             pin_all;
  logic [1:0]                       alu_free;
  logic [1:0]                       flex_take;
  logic [1:0][IW-1:0]               flex_idx;
  logic [NUM_SLOTS-1:0]             flex_placed;

  logic [NUM_UNITS-1:0]             gnt_vld_d, gnt_vld_q;
  logic [NUM_UNITS-1:0][IW-1:0]     gnt_idx_d, gnt_idx_q;
  logic [NUM_SLOTS-1:0]             stall_d,   stall_q;
  logic                             out_en;

  assign cls = slot_cls_i;

  // Classify each slot: tied to one unit, or free to use either ALU.
  always_comb begin
    pin_req  = '0;
    flex_req = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_vld_i[i]) begin
        if (home_unit(cls[i]) == U_NONE) begin
          flex_req[i] = 1'b1;
        end else begin
          pin_req[home_unit(cls[i])][i] = 1'b1;
        end
      end
    end
  end

  // Pass 1: tied classes, oldest wins per unit.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_pin
    steer_pick_oldest #(.N(NUM_SLOTS), .IW(IW)) u_pick (
      .req_i     (pin_req[u]),
      .blocked_i (unit_busy_i[u]),
      .win_vld_o (pin_vld[u]),
      .win_idx_o (pin_idx[u]),
      .win_1h_o  (pin_1h[u])
    );
  end

  always_comb begin
    pin_all = '0;
    for (int u = 0; u < NUM_UNITS; u++) pin_all |= pin_1h[u];
  end

  // Pass 2: flexible integer ops fill the ALUs left open.
  assign alu_free = ~unit_busy_i[1:0] & ~pin_vld[1:0];

  steer_flex_fill #(.N(NUM_SLOTS), .IW(IW)) u_flex (
    .req_i      (flex_req),
    .free_i     (alu_free),
    .take_o     (flex_take),
    .take_idx_o (flex_idx),
    .placed_o   (flex_placed)
  );

  // Next-state
  always_comb begin
    gnt_vld_d = pin_vld;
    gnt_idx_d = pin_idx;
    for (int a = 0; a < 2; a++) begin
      if (flex_take[a]) begin
        gnt_vld_d[a] = 1'b1;
        gnt_idx_d[a] = flex_idx[a];
      end
    end
    stall_d = slot_vld_i & ~(pin_all | flex_placed);
  end

  assign out_en = 1'b1;

  // Register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_vld_q <= '0;
      gnt_idx_q <= '0;
      stall_q   <= '0;
    end else if (out_en) begin
      gnt_vld_q <= gnt_vld_d;
      gnt_idx_q <= gnt_idx_d;
      stall_q   <= stall_d;
    end
  end

  assign grant_vld_o = gnt_vld_q;
  assign grant_idx_o = gnt_idx_q;
  assign stall_o     = stall_q;

  // Assertions
  AST_ALU1_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_d[0] |-> (cls[gnt_idx_d[0]] == OP_INT_ANY || cls[gnt_idx_d[0]] == OP_INT_BRSH)); // R1
  AST_ALU2_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_d[1] |-> (cls[gnt_idx_d[1]] == OP_INT_ANY || cls[gnt_idx_d[1]] == OP_INT_MULDIV)); // R2
  for (genvar f = 2; f < NUM_UNITS; f++) begin : g_fp_chk
    AST_FPU_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_vld_d[f] |-> (home_unit(cls[gnt_idx_d[f]]) == UNIT_W'(f))); // R4
  end
  AST_BUSY_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unit_busy_i) |=> ((grant_vld_o & $past(unit_busy_i)) == '0)); // R7
  AST_SINGLE_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_all & flex_placed) == '0); // R8
  AST_STALL_ONLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stall_o & ~$past(slot_vld_i)) == '0)); // R9

endmodule

// File: tb/exec_port_steer_tb_top.sv
module exec_port_steer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int IW = 2;
  localparam int NU = 6;

  logic              clk;
  logic              rst_n;
  logic [NS-1:0]     vld;
  logic [NS*3-1:0]   cls;
  logic [NU-1:0]     busy;
  logic [NU-1:0]     gvld;
  logic [NU*IW-1:0]  gidx;
  logic [NS-1:0]     stall;

  int n_chk = 0;
  int n_bad = 0;
  bit have_prev = 0;
  bit done = 0;
  string prev_tag;
  logic [NU-1:0]    e_vld;
  logic [NU*IW-1:0] e_idx;
  logic [NS-1:0]    e_stall;

  exec_port_steer #(.NUM_SLOTS(NS)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slot_vld_i  (vld),
    .slot_cls_i  (cls),
    .unit_busy_i (busy),
    .grant_vld_o (gvld),
    .grant_idx_o (gidx),
    .stall_o     (stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int home_of(input logic [2:0] c);
    if (c == 3'd1) return 0;
    if (c == 3'd2) return 1;
    if (c == 3'd3) return 2;
    if (c == 3'd4) return 3;
    if (c == 3'd5) return 4;
    if (c >= 3'd6) return 5;
    return -1;
  endfunction

  task automatic model(input logic [NS-1:0] v, input logic [NS*3-1:0] c,
                       input logic [NU-1:0] b);
    logic [NS-1:0] placed;
    e_vld = '0; e_idx = '0; placed = '0;
    for (int i = 0; i < NS; i++) begin
      int h;
      h = home_of(c[i*3 +: 3]);
      if (v[i] && h >= 0 && !b[h] && !e_vld[h]) begin
        e_vld[h] = 1'b1; e_idx[h*IW +: IW] = IW'(i); placed[i] = 1'b1;
      end
    end
    for (int i = 0; i < NS; i++) begin
      if (v[i] && c[i*3 +: 3] == 3'd0) begin
        for (int a = 0; a < 2; a++) begin
          if (!placed[i] && !b[a] && !e_vld[a]) begin
            e_vld[a] = 1'b1; e_idx[a*IW +: IW] = IW'(i); placed[i] = 1'b1;
          end
        end
      end
    end
    e_stall = v & ~placed;
  endtask

  task automatic compare(input string tag);
    bit bad;
    string t;
    bad = 0;
    t = tag;
    for (int u = 0; u < NU; u++) begin
      if (gvld[u] !== e_vld[u] || (e_vld[u] && gidx[u*IW +: IW] !== e_idx[u*IW +: IW])) begin
        if (!bad && tag == "") t = (u == 0) ? "R1" : (u == 1) ? "R2" : (u == 5) ? "R5" : "R4";
        bad = 1;
      end
    end
    if (stall !== e_stall) begin
      if (!bad && tag == "") t = "R9";
      bad = 1;
    end
    n_chk++;
    if (bad) begin
      n_bad++;
      if (n_bad < 20)
        $display("FAIL %s: vld=%b idx=%h stall=%b expected vld=%b idx=%h stall=%b",
                 t, gvld, gidx, stall, e_vld, e_idx, e_stall);
    end
  endtask

  // Check the result of the previous vector, then drive a new one.
  task automatic step(input logic [NS-1:0] v, input logic [NS*3-1:0] c,
                      input logic [NU-1:0] b, input string tag);
    @(negedge clk);
    if (have_prev) compare(prev_tag);
    model(v, c, b);
    vld = v; cls = c; busy = b;
    prev_tag = tag;
    have_prev = 1;
  endtask

  initial begin
    rst_n = 1'b0;
    vld = '1; cls = '0; busy = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (gvld !== '0 || stall !== '0 || gidx !== '0) begin
      n_bad++;
      $display("FAIL R10: reset vld=%b idx=%h stall=%b expected all zero", gvld, gidx, stall);
    end
    rst_n = 1'b1;

    // R3: lone class 0 op prefers ALU1; with ALU1 busy it takes ALU2
    step(4'b0001, 12'h000, 6'b000000, "R3");
    step(4'b0001, 12'h000, 6'b000001, "R3");
    // R8: slot0 class0, slot1 branch -> ALU1 slot1, ALU2 slot0
    step(4'b0011, {3'd0, 3'd0, 3'd1, 3'd0}, 6'b0, "R8");
    // R6: two FP divides -> unit 3 gets slot0, slot1 stalls
    step(4'b0011, {3'd0, 3'd0, 3'd4, 3'd4}, 6'b0, "R6");
    // R6: three class 0 ops -> slots 0,1 placed, slot 2 stalls
    step(4'b0111, 12'h000, 6'b0, "R6");
    // R7: everything busy -> all stalled
    step(4'b1111, {3'd6, 3'd5, 3'd2, 3'd0}, 6'b111111, "R7");
    // R10: idle input gives idle output one cycle later
    step(4'b0000, 12'h000, 6'b0, "R10");

    // Full sweep with no unit busy
    for (int c = 0; c < 4096; c++)
      for (int v = 0; v < 16; v++)
        step(4'(v), 12'(c), 6'b0, "");
    // Busy patterns over a class sample
    for (int b = 0; b < 64; b++)
      for (int c = 0; c < 4096; c += 8)
        step(4'hF, 12'(c), 6'(b), "R7");
    step(4'b0000, 12'h000, 6'b0, "R10");
    @(negedge clk);
    compare(prev_tag);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule